// File: doc/BRIEF.md
# Bitfield memory unit

This unit reads, tests and rewrites a bitfield of 1 to 32 bits held in big-endian, byte-addressed memory. The caller gives a base byte address, a signed bit offset that may reach far in either direction, a field length and an operation code. The unit folds the offset into a start byte address and a bit position inside that byte. It then fetches the one to five bytes that cover the field, one byte at a time, over a byte-wide request/acknowledge memory port.

The unit supports seven operations. It can extract the field as a signed or an unsigned number, and it can insert a new value into the field. It can invert the field, clear it or fill it with ones. It can also report where the first set bit lies. Each modifying operation writes the covered bytes back, in ascending address order, after all reads have finished. Every operation returns a 32-bit result and N/Z flags, which are valid in the single cycle when `done` is high.

Top module: `bf_mem_unit`

## Requirements
- R1: A `len_in` of 0 selects a 32-bit field. Any other value selects that many bits.
- R2: The field starts at byte `base_addr + floor(bit_ofs/8)`, at bit `bit_ofs mod 8` (always 0..7) inside that byte. Bit position 0 is the most significant bit of a byte, and bit numbering continues into the bytes at higher addresses.
- R3: For each operation the unit reads exactly `(bitpos + len - 1)/8 + 1` bytes (1 to 5), in ascending address order from the start byte. Any writes to those same bytes follow, in the same order, and no read comes after a write.
- R4: Op 0 returns the field zero-extended to 32 bits. Op 1 returns it sign-extended from its top bit.
- R5: Op 2 replaces the field with the low `len` bits of `ins_val` and leaves every bit outside the field unchanged. Its result and flags come from that value aligned to bit 31.
- R6: Op 3 inverts the field, op 4 clears it and op 5 sets all its bits. Other bits stay unchanged. The result is the old field aligned to bit 31, with zeros below it.
- R7: Op 6 returns `bit_ofs` plus the number of leading zeros in the field. If the field is zero, it returns `bit_ofs + len`.
- R8: `flag_n` is the top bit of the field and `flag_z` is set when the field is all zeros. Both are valid while `done` is high.
- R9: Ops 0, 1 and 6 issue no memory writes, and memory is left unchanged.
- R10: Once raised, `mem_req` stays high and `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_ack`.
- R11: After reset, `mem_req`, `busy` and `done` are low.
- R12: `done` is high for exactly one cycle per operation. `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_in | input | 3 | Operation code 0..6 |
| base_addr | input | AW | Base byte address |
| bit_ofs | input | 32 | Signed bit offset |
| len_in | input | 5 | Field length, 0 means 32 |
| ins_val | input | 32 | Value to insert (op 2) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 8 | Write data byte |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 8 | Read data byte, valid with ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench sweeps every length code against offsets on both sides of zero, with memory latencies from zero to two wait cycles. It checks results, flags and the whole memory image against a bit-by-bit reference model. Negative offsets are the main trap. A design that truncated the division instead of flooring it would start one byte too high and return a field shifted by eight bits. Length code 0 catches a design that treats it as an empty field, and fields that span five bytes catch a byte count that stops at four. Zero-filled memory exposes a find-first-one that does not add the length when no bit is set. Holding `start` high through an operation, with a writing opcode on the inputs, catches a sequencer that restarts while busy.

// File: rtl/bf_pkg.sv
// Shared types and sizes for the bitfield memory unit.
// Assumes fields of at most BF_MAXLEN bits and byte-wide memory.
package bf_pkg;
    parameter int BF_MAXLEN  = 32;
    parameter int BF_LENW    = 6;
    parameter int WIN_BYTES  = 5;
    parameter int WIN_BITS   = WIN_BYTES * 8;

    typedef enum logic [2:0] {
        BF_EXTU = 3'd0,
        BF_EXTS = 3'd1,
        BF_INS  = 3'd2,
        BF_CHG  = 3'd3,
        BF_CLR  = 3'd4,
        BF_SET  = 3'd5,
        BF_FFO  = 3'd6
    } bf_op_e;

    // True for operations that write the field back to memory.
    function automatic logic bf_writes(bf_op_e op);
        return (op == BF_INS) || (op == BF_CHG) || (op == BF_CLR) || (op == BF_SET);
    endfunction
endpackage

// File: rtl/bf_locate.sv
// Folds a base byte address and a signed bit offset into a start byte
// address and a bit position 0..7 inside it. Also decodes the length
// code and counts the bytes the field covers. Purely combinational.
// Assumes AW <= 32.
module bf_locate
    import bf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]      base_addr,
    input  logic [31:0]        bit_ofs,
    input  logic [4:0]         len_in,
    output logic [AW-1:0]      first_addr,
    output logic [2:0]         bitpos,
    output logic [BF_LENW-1:0] eff_len,
    output logic [2:0]         nbytes
);
    logic [AW-1:0]      byte_step;
    logic [BF_LENW-1:0] last_bit;

    // Floor division by 8 through an arithmetic shift; the remainder is the low three bits.
    always_comb begin
        byte_step  = AW'($signed(bit_ofs) >>> 3);
        first_addr = base_addr + byte_step;
        bitpos     = bit_ofs[2:0];
        eff_len    = (len_in == 5'd0) ? BF_LENW'(BF_MAXLEN) : {1'b0, len_in};
        last_bit   = {3'b000, bitpos} + eff_len - BF_LENW'(1);
        nbytes     = 3'((last_bit >> 3) + BF_LENW'(1));
    end
endmodule

// File: rtl/bf_field.sv
// Field datapath. Takes a window of up to five fetched bytes (first byte in
// the top bits), the bit position and the length. Produces the result, the
// flags and the rewritten window. One left shift aligns the field to bit 31;
// a mask shifted right by the same amount places the new bits.
module bf_field
    import bf_pkg::*;
(
    input  logic [WIN_BITS-1:0] win,
    input  logic [2:0]          bitpos,
    input  logic [BF_LENW-1:0]  len,
    input  bf_op_e              op,
    input  logic [31:0]         ins_val,
    input  logic [31:0]         bit_ofs,
    output logic [WIN_BITS-1:0] new_win,
    output logic [31:0]         result,
    output logic                flag_n,
    output logic                flag_z
);
    logic [BF_LENW-1:0]  rsh;
    logic [31:0]         lmask, aligned, fld_left, ins_left, flag_src;
    logic [WIN_BITS-1:0] wmask, ins_w;
    logic [BF_LENW-1:0]  lead;
    logic                seen;

    // Align the field and its mask to bit 31.
    always_comb begin
        rsh      = BF_LENW'(BF_MAXLEN) - len;
        lmask    = 32'hFFFF_FFFF << rsh;
        aligned  = 32'(({win, 32'h0} << bitpos) >> WIN_BITS);
        fld_left = aligned & lmask;
        ins_left = ins_val << rsh;
        wmask    = {lmask, 8'h00} >> bitpos;
        ins_w    = {ins_left, 8'h00} >> bitpos;
    end

    // Count leading zeros of the field; the length when no bit is set.
    always_comb begin
        lead = len;
        seen = 1'b0;
        for (int i = 0; i < BF_MAXLEN; i++) begin
            if (!seen && fld_left[BF_MAXLEN-1-i]) begin
                lead = BF_LENW'(i);
                seen = 1'b1;
            end
        end
    end

    // Pick the result, the rewritten window and the flag source by opcode.
    always_comb begin
        new_win  = win;
        flag_src = fld_left;
        unique case (op)
            BF_EXTS: result = 32'($signed(fld_left) >>> rsh);
            BF_INS: begin
                result   = ins_left;
                flag_src = ins_left;
                new_win  = (win & ~wmask) | (ins_w & wmask);
            end
            BF_CHG: begin result = fld_left; new_win = win ^ wmask;  end
            BF_CLR: begin result = fld_left; new_win = win & ~wmask; end
            BF_SET: begin result = fld_left; new_win = win | wmask;  end
            BF_FFO:  result = bit_ofs + 32'(lead);
            default: result = fld_left >> rsh;
        endcase
        flag_n = flag_src[31];
        flag_z = (flag_src == 32'h0);
    end
endmodule

// File: rtl/bf_mem_unit.sv
// Top of the bitfield memory unit. Latches a request while idle, then reads
// the covered bytes one at a time, and for modifying operations writes them
// back in the same order. Raises done for one cycle at the end. Memory
// requests hold until acknowledged; an ack may arrive in the same cycle as
// the request.
module bf_mem_unit
    import bf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_in,
    input  logic [AW-1:0] base_addr,
    input  logic [31:0]   bit_ofs,
    input  logic [4:0]    len_in,
    input  logic [31:0]   ins_val,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [31:0]   result,
    output logic          flag_n,
    output logic          flag_z
);
    typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} state_e;

    state_e                        state;
    bf_op_e                        op_q;
    logic [AW-1:0]                 addr_q;
    logic [2:0]                    bitpos_q, nbytes_q, idx;
    logic [BF_LENW-1:0]            len_q;
    logic [31:0]                   ins_q, ofs_q;
    logic [WIN_BYTES-1:0][7:0]     win_q;
    logic [WIN_BYTES-1:0][7:0]     new_win;
    logic [AW-1:0]                 loc_addr;
    logic [2:0]                    loc_bitpos, loc_nbytes, slot;
    logic [BF_LENW-1:0]            loc_len;
    logic                          last_byte;

    bf_locate #(.AW(AW)) u_locate (
        .base_addr (base_addr),
        .bit_ofs   (bit_ofs),
        .len_in    (len_in),
        .first_addr(loc_addr),
        .bitpos    (loc_bitpos),
        .eff_len   (loc_len),
        .nbytes    (loc_nbytes)
    );

    bf_field u_field (
        .win    (win_q),
        .bitpos (bitpos_q),
        .len    (len_q),
        .op     (op_q),
        .ins_val(ins_q),
        .bit_ofs(ofs_q),
        .new_win(new_win),
        .result (result),
        .flag_n (flag_n),
        .flag_z (flag_z)
    );

    // Byte slot in the window for the current index, and the last-byte test.
    always_comb begin
        slot      = 3'(WIN_BYTES - 1) - idx;
        last_byte = (idx == nbytes_q - 3'd1);
    end

    // Drive the memory port and the status outputs from the state.
    always_comb begin
        mem_req   = (state == S_RD) || (state == S_WR);
        mem_we    = (state == S_WR);
        mem_addr  = addr_q + AW'(idx);
        mem_wdata = new_win[slot];
        busy      = (state != S_IDLE);
        done      = (state == S_FIN);
    end

    // Sequencer: accept, read, optionally write back, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= BF_EXTU;
            addr_q   <= '0;
            bitpos_q <= '0;
            nbytes_q <= 3'd1;
            len_q    <= '0;
            ins_q    <= '0;
            ofs_q    <= '0;
            idx      <= '0;
            win_q    <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    op_q     <= bf_op_e'(op_in);
                    addr_q   <= loc_addr;
                    bitpos_q <= loc_bitpos;
                    nbytes_q <= loc_nbytes;
                    len_q    <= loc_len;
                    ins_q    <= ins_val;
                    ofs_q    <= bit_ofs;
                    idx      <= '0;
                    win_q    <= '0;
                    state    <= S_RD;
                end
                S_RD: if (mem_ack) begin
                    win_q[slot] <= mem_rdata;
                    if (last_byte) begin
                        idx   <= '0;
                        state <= bf_writes(op_q) ? S_WR : S_FIN;
                    end else begin
                        idx <= idx + 3'd1;
                    end
                end
                S_WR: if (mem_ack) begin
                    if (last_byte) state <= S_FIN;
                    else           idx   <= idx + 3'd1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bf_mem_unit_chk.sv
// Protocol and sequencing checks for bf_mem_unit, attached with bind.
module bf_mem_unit_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic          busy,
    input logic          done,
    input logic [2:0]    op_q
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req); // R10
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && busy)); // R3
    AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> !(mem_req && !mem_we)); // R3
    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_q == 3'd0 || op_q == 3'd1 || op_q == 3'd6)) |-> !mem_we); // R9
endmodule

bind bf_mem_unit bf_mem_unit_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .busy     (busy),
    .done     (done),
    .op_q     (op_q)
);

// File: tb/sim_bf_mem_unit.sv
`timescale 1ns/1ps
module sim_bf_mem_unit;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op_in = '0;
    logic [AW-1:0] base_addr = '0;
    logic [31:0]   bit_ofs = '0;
    logic [4:0]    len_in = '0;
    logic [31:0]   ins_val = '0;
    logic          mem_req, mem_we, busy, done, flag_n, flag_z;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_ack = 1'b0;
    logic [7:0]    mem_rdata = '0;
    logic [31:0]   result;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bf_mem_unit #(.AW(AW)) u0 (.*);

    // Memory model: 64 bytes, ack after a programmable wait, loaded on request.
    logic [7:0] mem [64];
    logic [7:0] init_mem [64];
    logic [7:0] ref_mem [64];
    logic       load_mem = 1'b0;
    int         dly_cfg = 0;
    int         wcnt = 0;

    always @(negedge clk) begin
        if (load_mem) begin
            for (int i = 0; i < 64; i++) mem[i] = init_mem[i];
        end
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt < dly_cfg) begin
                wcnt <= wcnt + 1;
            end else begin
                wcnt    <= 0;
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[5:0]] = mem_wdata;
                else        mem_rdata <= mem[mem_addr[5:0]];
            end
        end
    end

    // Handshake monitor: counts reads and writes, checks address order.
    int exp_first = 0;
    int rd_cnt = 0, wr_cnt = 0, ord_err = 0;
    always @(posedge clk) begin
        if (start && !busy) begin
            rd_cnt  = 0;
            wr_cnt  = 0;
            ord_err = 0;
        end else if (mem_req && mem_ack) begin
            if (mem_we) begin
                if (int'(mem_addr) != exp_first + wr_cnt) ord_err++;
                wr_cnt++;
            end else begin
                if (wr_cnt != 0 || int'(mem_addr) != exp_first + rd_cnt) ord_err++;
                rd_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit rbit(input int g);
        return ref_mem[g / 8][7 - (g % 8)];
    endfunction

    // One operation end to end against the bit-level reference.
    task automatic run_op(input int op, input int base, input int ofs, input int lenc,
                          input logic [31:0] val, input int d, input bit hold, input bit zfill);
        int g0, L, bp, nb, lead, cyc;
        logic [31:0] fld, exp_res, flag_src;
        bit wr, mem_ok;
        string rq;
        g0 = base * 8 + ofs;
        L  = (lenc == 0) ? 32 : lenc;
        bp = g0 % 8;
        nb = (bp + L - 1) / 8 + 1;
        wr = (op >= 2 && op <= 5);
        for (int i = 0; i < 64; i++) init_mem[i] = zfill ? 8'h00 : 8'($urandom);
        dly_cfg = d;
        @(posedge clk); load_mem = 1'b1;
        @(posedge clk); load_mem = 1'b0;
        for (int i = 0; i < 64; i++) ref_mem[i] = init_mem[i];
        fld = '0;
        for (int k = 0; k < L; k++) fld = {fld[30:0], rbit(g0 + k)};
        lead = L;
        for (int k = 0; k < L; k++) if (fld[L-1-k]) begin lead = k; break; end
        flag_src = fld << (32 - L);
        case (op)
            0: exp_res = fld;
            1: exp_res = fld[L-1] ? (fld | (32'hFFFF_FFFF << L)) : fld;
            2: begin exp_res = val << (32 - L); flag_src = exp_res; end
            6: exp_res = 32'(ofs + lead);
            default: exp_res = fld << (32 - L);
        endcase
        for (int k = 0; k < L; k++) begin
            int g = g0 + k;
            bit nbv;
            case (op)
                2: nbv = val[L-1-k];
                3: nbv = ~fld[L-1-k];
                4: nbv = 1'b0;
                5: nbv = 1'b1;
                default: nbv = fld[L-1-k];
            endcase
            ref_mem[g / 8][7 - (g % 8)] = nbv;
        end
        exp_first = g0 / 8;
        @(negedge clk);
        op_in = 3'(op); base_addr = AW'(base); bit_ofs = 32'(ofs);
        len_in = 5'(lenc); ins_val = val; start = 1'b1;
        @(negedge clk);
        if (hold) op_in = 3'd5;
        else start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        start = 1'b0;
        rq = (op <= 1) ? "R4" : (op == 2) ? "R5" : (op == 6) ? "R7" : "R6";
        if (lenc == 0) rq = {rq, "/R1"};
        if (hold) rq = {rq, "/R12"};
        check(done === 1'b1, {rq, " done"}, 32'(done), 32'd1);
        check(result === exp_res, {rq, " result"}, result, exp_res);
        check({flag_n, flag_z} === {flag_src[31], flag_src == 0}, "R8 flags",
              {30'd0, flag_n, flag_z}, {30'd0, flag_src[31], flag_src == 0});
        @(negedge clk);
        check(done === 1'b0, "R12 done pulse", 32'(done), 32'd0);
        mem_ok = 1'b1;
        for (int i = 0; i < 64; i++) if (mem[i] !== ref_mem[i]) mem_ok = 1'b0;
        check(mem_ok, wr ? {rq, " memory"} : "R9 memory", 32'(mem_ok), 32'd1);
        check(rd_cnt == nb && wr_cnt == (wr ? nb : 0) && ord_err == 0, "R2/R3 access count",
              32'(rd_cnt * 256 + wr_cnt * 16 + ord_err), 32'(nb * 256 + (wr ? nb : 0) * 16));
    endtask

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_req === 1'b0 && busy === 1'b0 && done === 1'b0, "R11 reset",
              {29'd0, mem_req, busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        n = 0;
        for (int op = 0; op < 7; op++)
            for (int lc = 0; lc < 32; lc++)
                for (int of = -21; of <= 21; of += 6) begin
                    run_op(op, 32, of, lc, $urandom, n % 3, 1'b0, (n % 11) == 0);
                    n++;
                end
        run_op(6, 20, -37, 0, 32'h0, 1, 1'b0, 1'b1);   // R7 zero field, R1 full length
        run_op(1, 24, 7, 0, 32'h0, 0, 1'b0, 1'b0);     // R3 five-byte span
        run_op(0, 30, -1, 8, 32'h0, 2, 1'b1, 1'b0);    // R12 start held with write op
        run_op(2, 16, 13, 1, 32'h1, 0, 1'b0, 1'b0);    // R5 single bit
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule